// File: doc/BRIEF.md
# Command ring write controller

This block owns a circular queue of command words that a host fills and a downstream consumer empties. The host pushes 32-bit command words, and the controller stores each word one slot past the current write pointer before it moves the pointer. A push that would make the write pointer catch up with the read pointer is refused. The host can also load the write pointer directly, which is how a driver places it at a known position before it starts.

The read pointer belongs to the hardware. The host cannot load it. The host can only send it back to zero through a two-step handshake: it writes the reset flag, polls until the flag reads back as set, then writes zero and polls until the whole register reads zero. A run bit gates the consumer. While the bit is set, each pop advances the read pointer and presents the word in the new slot, together with the target device number taken from the top nibble of the word. When the block is powered down, both pointer registers read as all ones, and the block takes neither writes nor pushes.

Top module: `cmd_ring_ctrl`

## Requirements
- R1: After reset the write pointer and the read pointer both read 0x0000. The ring is empty and not full, run status is 0 and no output word is valid.
- R2: An accepted push stores the word at slot (write pointer + 1) mod 256 and moves the write pointer to that slot. It raises `push_ack` for one cycle after the clock edge that takes the push. Slot 0 is therefore never the first slot filled after reset.
- R3: `ring_full` is high when (write pointer + 1) mod 256 equals the read pointer. A push in that state raises `push_rej` for one cycle and leaves the write pointer and ring contents unchanged.
- R4: A pop takes place on a clock edge where `pop_rdy`, run and power are all high, no read-pointer reset is in progress, and the read pointer differs from the write pointer. The pop advances the read pointer by one. In the next cycle `out_vld` is high and `out_word` holds the word in the new slot. With equal pointers no pop happens.
- R5: With the run request clear, no pop happens. `run_sts` follows the last written run value one cycle after the write takes effect.
- R6: Writing a read-pointer value with bit 15 set starts a reset. Bit 15 reads 0 until the reset takes effect, a bounded number of cycles later. It then reads 1 with the pointer field at 0, so the register reads 0x8000. No pops happen during the handshake.
- R7: Writing 0x0000 while the reset flag reads 1 clears the flag a bounded number of cycles later, and the register then reads 0x0000. A read-pointer write with bit 15 clear while no reset is pending has no effect.
- R8: `out_addr` is bits 31:28 of the presented word when that value is below the supported device count (4 by default), and 0 otherwise.
- R9: With `pwr_on` low, both pointer registers read 0xFFFF. Pushes are rejected, register writes are ignored and no pops happen. The pointers and contents are kept for when power returns.
- R10: Both pointers wrap from 255 to 0. The slot after 255 is slot 0, for both pushes and pops.
- R11: A write-pointer write loads the pointer (bits 7:0) without altering ring contents. It takes priority over a push in the same cycle, and that push is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_on | input | 1 | High while the block is powered up |
| push_en | input | 1 | Push request for `push_word` |
| push_word | input | 32 | Command word to push |
| push_ack | output | 1 | One-cycle pulse: previous push accepted |
| push_rej | output | 1 | One-cycle pulse: previous push refused |
| wp_wr_en | input | 1 | Write-pointer register write strobe |
| wp_wr_data | input | 8 | Value to load into the write pointer |
| wp_rd_data | output | 16 | Write-pointer register read value |
| rp_wr_en | input | 1 | Read-pointer register write strobe |
| rp_wr_data | input | 16 | Read-pointer write value; bit 15 is the reset flag |
| rp_rd_data | output | 16 | Read-pointer register read value; bit 15 is the reset flag |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_run | input | 1 | Run value written with `ctl_wr_en` |
| run_sts | output | 1 | Run status read back |
| ring_full | output | 1 | Ring cannot take another push |
| ring_empty | output | 1 | Read and write pointers are equal |
| pop_rdy | input | 1 | Consumer ready for the next word |
| out_vld | output | 1 | `out_word` and `out_addr` hold a freshly popped entry |
| out_word | output | 32 | Popped command word |
| out_addr | output | 4 | Target device number of the popped word |

## Verification
If the write pointer is off by one, the mistake first shows on the pop after the bad push: `out_word` carries the neighbouring slot, or stale content, in the cycle after the pop. A broken full comparison shows as a missing `push_rej` pulse, one cycle after the push that should have been refused. That push then overwrites an entry that has not been popped yet, and the overwrite is seen as a wrong word roughly a ring's length of pops later. A stuck handshake state shows in the read-pointer register, within the few cycles of reset latency: the flag never rises, never falls, or the pointer field is not zero while the flag is set. After that, pops stay blocked.

// File: rtl/cmd_ring_pkg.sv
package cmd_ring_pkg;

    // States of the read-pointer reset handshake
    typedef enum logic [1:0] {
        RP_IDLE     = 2'd0,
        RP_RST_WAIT = 2'd1,
        RP_RST_ACK  = 2'd2,
        RP_CLR_WAIT = 2'd3
    } rp_state_e;

endpackage

// File: rtl/cmd_ring_mem.sv
module cmd_ring_mem #(
    parameter int DEPTH  = 256,
    parameter int DATA_W = 32,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PTR_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] slot_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            slot_q[waddr] <= wdata;
        end
    end

    assign rdata = slot_q[raddr];

endmodule

// File: rtl/cmd_ring_wr.sv
module cmd_ring_wr #(
    parameter int PTR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_on,
    input  logic             push_en,
    input  logic             wp_wr_en,
    input  logic [PTR_W-1:0] wp_wr_data,
    input  logic [PTR_W-1:0] rp_i,
    output logic [PTR_W-1:0] wp_o,
    output logic             full_o,
    output logic             empty_o,
    output logic             mem_we_o,
    output logic [PTR_W-1:0] mem_waddr_o,
    output logic             push_ack_o,
    output logic             push_rej_o
);

    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic             ack;
        logic             rej;
    } wr_st_t;

    wr_st_t           st_d, st_q;
    logic [PTR_W-1:0] wp_inc;
    logic             full;

    always_comb begin
        wp_inc   = st_q.wp + PTR_W'(1);
        full     = (wp_inc == rp_i);
        st_d     = st_q;
        st_d.ack = 1'b0;
        st_d.rej = 1'b0;
        mem_we_o = 1'b0;
        if (pwr_on && wp_wr_en) begin
            st_d.wp = wp_wr_data;
        end
        if (push_en) begin
            if (!pwr_on || wp_wr_en || full) begin
                st_d.rej = 1'b1;
            end else begin
                mem_we_o = 1'b1;
                st_d.wp  = wp_inc;
                st_d.ack = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wp_o        = st_q.wp;
    assign full_o      = full;
    assign empty_o     = (st_q.wp == rp_i);
    assign mem_waddr_o = wp_inc;
    assign push_ack_o  = st_q.ack;
    assign push_rej_o  = st_q.rej;

    // R2
    push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_en && pwr_on && !wp_wr_en && !full) |=>
            (push_ack_o && (wp_o == $past(wp_o) + PTR_W'(1))));

    // R3
    full_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_en && full && !wp_wr_en) |=> (push_rej_o && !push_ack_o && $stable(wp_o)));

endmodule

// File: rtl/cmd_ring_rd.sv
module cmd_ring_rd
    import cmd_ring_pkg::*;
#(
    parameter int PTR_W   = 8,
    parameter int REG_W   = 16,
    parameter int DATA_W  = 32,
    parameter int DEV_W   = 4,
    parameter int NUM_DEV = 4,
    parameter int RST_LAT = 3,
    localparam int CNT_W  = $clog2(RST_LAT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_on,
    input  logic              rp_wr_en,
    input  logic [REG_W-1:0]  rp_wr_data,
    input  logic              ctl_wr_en,
    input  logic              ctl_run,
    input  logic              pop_rdy,
    input  logic [PTR_W-1:0]  wp_i,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [PTR_W-1:0]  mem_raddr_o,
    output logic [PTR_W-1:0]  rp_o,
    output logic              rst_flag_o,
    output logic              run_sts_o,
    output logic              out_vld_o,
    output logic [DATA_W-1:0] out_word_o,
    output logic [DEV_W-1:0]  out_addr_o
);

    typedef struct packed {
        rp_state_e         state;
        logic [CNT_W-1:0]  cnt;
        logic [PTR_W-1:0]  rp;
        logic              run_req;
        logic              run_sts;
        logic              vld;
        logic [DATA_W-1:0] word;
        logic [DEV_W-1:0]  addr;
    } rd_st_t;

    rd_st_t           st_d, st_q;
    logic [PTR_W-1:0] rp_inc;
    logic [DEV_W-1:0] dev_field;
    logic             pop;

    always_comb begin
        rp_inc      = st_q.rp + PTR_W'(1);
        dev_field   = mem_rdata[DATA_W-1 -: DEV_W];
        st_d        = st_q;
        st_d.vld    = 1'b0;
        st_d.run_sts = st_q.run_req;
        if (pwr_on && ctl_wr_en) begin
            st_d.run_req = ctl_run;
        end
        unique case (st_q.state)
            RP_IDLE: begin
                if (pwr_on && rp_wr_en && rp_wr_data[REG_W-1]) begin
                    st_d.state = RP_RST_WAIT;
                    st_d.cnt   = CNT_W'(RST_LAT - 1);
                end
            end
            RP_RST_WAIT: begin
                if (st_q.cnt == '0) begin
                    st_d.state = RP_RST_ACK;
                    st_d.rp    = '0;
                end else begin
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                end
            end
            RP_RST_ACK: begin
                if (pwr_on && rp_wr_en && (rp_wr_data == '0)) begin
                    st_d.state = RP_CLR_WAIT;
                    st_d.cnt   = CNT_W'(RST_LAT - 1);
                end
            end
            RP_CLR_WAIT: begin
                if (st_q.cnt == '0) begin
                    st_d.state = RP_IDLE;
                end else begin
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                end
            end
            default: st_d.state = RP_IDLE;
        endcase
        pop = pwr_on && st_q.run_req && pop_rdy &&
              (st_q.state == RP_IDLE) && (st_q.rp != wp_i);
        if (pop) begin
            st_d.rp   = rp_inc;
            st_d.vld  = 1'b1;
            st_d.word = mem_rdata;
            if ({1'b0, dev_field} < (DEV_W + 1)'(NUM_DEV)) begin
                st_d.addr = dev_field;
            end else begin
                st_d.addr = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= RP_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_raddr_o = rp_inc;
    assign rp_o        = st_q.rp;
    assign rst_flag_o  = (st_q.state == RP_RST_ACK) || (st_q.state == RP_CLR_WAIT);
    assign run_sts_o   = st_q.run_sts;
    assign out_vld_o   = st_q.vld;
    assign out_word_o  = st_q.word;
    assign out_addr_o  = st_q.addr;

    // R4
    pop_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> (out_vld_o && (rp_o == $past(rp_o) + PTR_W'(1))));

    // R5
    stopped_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.run_req |=> !out_vld_o);

    // R6
    ack_ptr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == RP_RST_ACK) |-> (rp_o == '0));

    // R7
    clear_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == RP_CLR_WAIT && st_q.cnt == '0) |=> (!rst_flag_o && rp_o == '0));

    // R9
    unpowered_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_on |=> !out_vld_o);

endmodule

// File: rtl/cmd_ring_ctrl.sv
module cmd_ring_ctrl #(
    parameter int DEPTH   = 256,
    parameter int DATA_W  = 32,
    parameter int REG_W   = 16,
    parameter int DEV_W   = 4,
    parameter int NUM_DEV = 4,
    parameter int RST_LAT = 3,
    localparam int PTR_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_on,
    input  logic              push_en,
    input  logic [DATA_W-1:0] push_word,
    output logic              push_ack,
    output logic              push_rej,
    input  logic              wp_wr_en,
    input  logic [PTR_W-1:0]  wp_wr_data,
    output logic [REG_W-1:0]  wp_rd_data,
    input  logic              rp_wr_en,
    input  logic [REG_W-1:0]  rp_wr_data,
    output logic [REG_W-1:0]  rp_rd_data,
    input  logic              ctl_wr_en,
    input  logic              ctl_run,
    output logic              run_sts,
    output logic              ring_full,
    output logic              ring_empty,
    input  logic              pop_rdy,
    output logic              out_vld,
    output logic [DATA_W-1:0] out_word,
    output logic [DEV_W-1:0]  out_addr
);

    logic [PTR_W-1:0]  wp, rp, waddr, raddr;
    logic              mem_we, rst_flag;
    logic [DATA_W-1:0] rdata;

    cmd_ring_mem #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (waddr),
        .wdata (push_word),
        .raddr (raddr),
        .rdata (rdata)
    );

    cmd_ring_wr #(.PTR_W(PTR_W)) u_wr (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwr_on      (pwr_on),
        .push_en     (push_en),
        .wp_wr_en    (wp_wr_en),
        .wp_wr_data  (wp_wr_data),
        .rp_i        (rp),
        .wp_o        (wp),
        .full_o      (ring_full),
        .empty_o     (ring_empty),
        .mem_we_o    (mem_we),
        .mem_waddr_o (waddr),
        .push_ack_o  (push_ack),
        .push_rej_o  (push_rej)
    );

    cmd_ring_rd #(
        .PTR_W   (PTR_W),
        .REG_W   (REG_W),
        .DATA_W  (DATA_W),
        .DEV_W   (DEV_W),
        .NUM_DEV (NUM_DEV),
        .RST_LAT (RST_LAT)
    ) u_rd (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwr_on      (pwr_on),
        .rp_wr_en    (rp_wr_en),
        .rp_wr_data  (rp_wr_data),
        .ctl_wr_en   (ctl_wr_en),
        .ctl_run     (ctl_run),
        .pop_rdy     (pop_rdy),
        .wp_i        (wp),
        .mem_rdata   (rdata),
        .mem_raddr_o (raddr),
        .rp_o        (rp),
        .rst_flag_o  (rst_flag),
        .run_sts_o   (run_sts),
        .out_vld_o   (out_vld),
        .out_word_o  (out_word),
        .out_addr_o  (out_addr)
    );

    assign wp_rd_data = pwr_on ? REG_W'(wp) : '1;
    assign rp_rd_data = pwr_on ? {rst_flag, {(REG_W-1-PTR_W){1'b0}}, rp} : '1;

    // R8
    dev_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> ({1'b0, out_addr} < (DEV_W + 1)'(NUM_DEV)));

    // R9
    unpowered_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_en && !pwr_on) |=> (push_rej && !push_ack));

endmodule

// File: tb/sim_cmd_ring_ctrl.sv
`timescale 1ns/1ps
module sim_cmd_ring_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_on = 1'b1;
    logic        push_en = 1'b0;
    logic [31:0] push_word = '0;
    logic        push_ack, push_rej;
    logic        wp_wr_en = 1'b0;
    logic [7:0]  wp_wr_data = '0;
    logic [15:0] wp_rd_data;
    logic        rp_wr_en = 1'b0;
    logic [15:0] rp_wr_data = '0;
    logic [15:0] rp_rd_data;
    logic        ctl_wr_en = 1'b0;
    logic        ctl_run = 1'b0;
    logic        run_sts, ring_full, ring_empty;
    logic        pop_rdy = 1'b0;
    logic        out_vld;
    logic [31:0] out_word;
    logic [3:0]  out_addr;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    cmd_ring_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on),
        .push_en(push_en), .push_word(push_word), .push_ack(push_ack), .push_rej(push_rej),
        .wp_wr_en(wp_wr_en), .wp_wr_data(wp_wr_data), .wp_rd_data(wp_rd_data),
        .rp_wr_en(rp_wr_en), .rp_wr_data(rp_wr_data), .rp_rd_data(rp_rd_data),
        .ctl_wr_en(ctl_wr_en), .ctl_run(ctl_run), .run_sts(run_sts),
        .ring_full(ring_full), .ring_empty(ring_empty),
        .pop_rdy(pop_rdy), .out_vld(out_vld), .out_word(out_word), .out_addr(out_addr)
    );

    // {expected device, command word}
    localparam logic [35:0] VEC [6] = '{
        {4'h0, 32'h0A00_0001}, {4'h3, 32'h3B00_0002}, {4'h0, 32'h4C00_0003},
        {4'h0, 32'hFD00_0004}, {4'h1, 32'h1E00_0005}, {4'h2, 32'h2F00_0006}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic push(input logic [31:0] w);
        push_en = 1'b1; push_word = w;
        tick();
        push_en = 1'b0;
    endtask

    task automatic pop_once();
        pop_rdy = 1'b1;
        tick();
        pop_rdy = 1'b0;
    endtask

    task automatic ctl_write(input logic v);
        ctl_wr_en = 1'b1; ctl_run = v;
        tick();
        ctl_wr_en = 1'b0;
    endtask

    task automatic rp_write(input logic [15:0] v);
        rp_wr_en = 1'b1; rp_wr_data = v;
        tick();
        rp_wr_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int cnt;
        logic [31:0] last_w, prev_w;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        chk("R1 wp", wp_rd_data, 32'h0);
        chk("R1 rp", rp_rd_data, 32'h0);
        chk("R1 empty/full/run/vld", {ring_empty, ring_full, run_sts, out_vld}, 32'b1000);

        // R2 table pushes
        for (int i = 0; i < 6; i++) begin
            push(VEC[i][31:0]);
            chk("R2 ack", {push_ack, push_rej}, 32'b10);
            chk("R2 wp", wp_rd_data, i + 1);
        end

        // R5 no pop while stopped
        pop_rdy = 1'b1;
        repeat (3) begin
            tick();
            chk("R5 stopped vld", out_vld, 0);
        end
        pop_rdy = 1'b0;
        chk("R5 stopped rp", rp_rd_data, 0);

        ctl_write(1'b1);
        tick();
        chk("R5 run_sts set", run_sts, 1);

        // R4 R8 table pops
        for (int i = 0; i < 6; i++) begin
            pop_once();
            chk("R4 vld", out_vld, 1);
            chk("R4 word", out_word, VEC[i][31:0]);
            chk("R8 addr", out_addr, VEC[i][35:32]);
            chk("R4 rp", rp_rd_data, i + 1);
        end
        chk("R4 empty", ring_empty, 1);
        pop_once();
        chk("R4 no pop when empty", out_vld, 0);

        // R5 stop
        ctl_write(1'b0);
        tick();
        chk("R5 run_sts clear", run_sts, 0);
        push(32'h7777_0007);
        pop_once();
        chk("R5 stopped after clear", out_vld, 0);

        // R7 plain rp write ignored
        rp_write(16'h0003);
        chk("R7 ignored write", rp_rd_data, 32'h6);

        // R6 reset handshake
        rp_write(16'h8000);
        chk("R6 flag not yet", rp_rd_data[15], 0);
        cnt = 0;
        while (rp_rd_data[15] !== 1'b1 && cnt < 1000) begin tick(); cnt++; end
        chk("R6 ack read", rp_rd_data, 32'h8000);
        rp_write(16'h0000);
        cnt = 0;
        while (rp_rd_data !== 16'h0000 && cnt < 1000) begin tick(); cnt++; end
        chk("R7 cleared", rp_rd_data, 32'h0);

        ctl_write(1'b1);
        pop_once();
        chk("R7 pop after clear", out_word, VEC[0][31:0]);
        ctl_write(1'b0);

        // R11 R3 R10 full and wrap
        wp_wr_en = 1'b1; wp_wr_data = 8'hFE;
        tick();
        wp_wr_en = 1'b0;
        chk("R11 wp load", wp_rd_data, 32'hFE);
        push(32'hA5A5_00FF);
        chk("R10 wp 255", wp_rd_data, 32'hFF);
        chk("R3 not full", ring_full, 0);
        push(32'h2B2B_0100);
        chk("R10 wp wraps", wp_rd_data, 32'h0);
        chk("R3 full", ring_full, 1);
        push(32'hDEAD_BEEF);
        chk("R3 reject", {push_ack, push_rej}, 32'b01);
        chk("R3 wp kept", wp_rd_data, 32'h0);

        // R11 push collides with wp write
        wp_wr_en = 1'b1; wp_wr_data = 8'h00; push_en = 1'b1; push_word = 32'h1111_1111;
        tick();
        wp_wr_en = 1'b0; push_en = 1'b0;
        chk("R11 push loses", {push_ack, push_rej}, 32'b01);

        // R10 drain through wrap
        ctl_write(1'b1);
        pop_rdy = 1'b1;
        cnt = 0; last_w = '0; prev_w = '0;
        for (int k = 0; k < 262; k++) begin
            tick();
            if (out_vld) begin cnt++; prev_w = last_w; last_w = out_word; end
        end
        pop_rdy = 1'b0;
        chk("R10 drain count", cnt, 255);
        chk("R10 slot 255", prev_w, 32'hA5A5_00FF);
        chk("R10 slot 0", last_w, 32'h2B2B_0100);
        chk("R10 rp wraps", rp_rd_data, 32'h0);

        // R9 power down
        push(32'h2C00_0042);
        pwr_on = 1'b0;
        #1;
        chk("R9 wp ones", wp_rd_data, 32'hFFFF);
        chk("R9 rp ones", rp_rd_data, 32'hFFFF);
        push(32'h3333_3333);
        chk("R9 push rejected", {push_ack, push_rej}, 32'b01);
        pop_rdy = 1'b1;
        repeat (3) begin
            tick();
            chk("R9 no pop", out_vld, 0);
        end
        pop_rdy = 1'b0;
        pwr_on = 1'b1;
        #1;
        chk("R9 wp kept", wp_rd_data, 32'h1);
        chk("R9 rp kept", rp_rd_data, 32'h0);
        pop_once();
        chk("R9 word kept", out_word, 32'h2C00_0042);
        chk("R8 addr 2", out_addr, 2);
        chk("R9 empty", ring_empty, 1);

        finish_run();
    end

endmodule